// File: doc/BRIEF.md
# Link Training Completion Watcher

This block decides whether a serial link port has finished training, by watching the 5-bit training state code that the port exposes. A pulse on `start` opens a wait window. The state code is examined on that same clock edge. If the link is already operational, the block reports success on the next cycle with no added delay. Otherwise it looks at the code again once per polling interval. One interval is one millisecond, and an internal prescaler derives it from the system clock.

Three codes count as an operational link: the active state, the standby state and the L1 idle state. Every other code counts as down. This includes L2 idle, because leaving L2 needs action from outside the block. If no check finds the link up within `MAX_POLLS` intervals, the block gives up and reports a timeout. Whichever result is reached is held steady until the next `start` pulse.

Top module: `link_wait_monitor`

## Requirements
- R1: While reset is asserted, and after it is released until the first `start`, `done`, `link_up` and `timeout` are all 0.
- R2: Only the codes 5'h11, 5'h12 and 5'h14 count as link up. Every other code counts as down, including 5'h15.
- R3: If the code seen on the clock edge that samples `start` is an up code, then `done` and `link_up` are 1 in the very next cycle.
- R4: While waiting, the code is sampled only on interval boundaries, which fall every `CLKS_PER_MS` clock edges after the start edge. An up code present only between boundaries has no effect.
- R5: If the first up code is seen on boundary k, where 1 <= k < `MAX_POLLS`, then `done` and `link_up` rise right after the edge that is k*`CLKS_PER_MS` cycles after the start edge.
- R6: If no check finds the link up, `done` and `timeout` rise right after the edge that is `MAX_POLLS`*`CLKS_PER_MS` cycles after the start edge. The code on that final boundary is ignored.
- R7: Once `done` is 1, all three outputs hold steady until the next `start`, whatever the code does.
- R8: A `start` pulse during a wait clears the outputs and restarts the window from its beginning.
- R9: `link_up` and `timeout` are never 1 together, and `done` is 1 exactly when one of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a wait window |
| ltssm_state | input | 5 | Training state code from the port |
| link_up | output | 1 | Wait ended with the link operational |
| timeout | output | 1 | Wait ended at the deadline |
| done | output | 1 | Wait has ended, with either result |

## Verification
The assertions assume only that reset is held low for the first edges. `start` may arrive at any time, and the state code may take any value on any cycle. The bound checker measures timing with a counter of edges since the last `start`, so result edges are checked against interval boundaries without deep history. The stimulus covers all 32 codes. It puts short up-code glitches between boundaries, presents an up code on the final boundary, and restarts in mid-wait. The bench uses a short prescale period and a reduced poll limit so that full timeouts stay short.

// File: rtl/link_wait_monitor.sv
module link_wait_monitor #(
  parameter int CLKS_PER_MS = 100000,
  parameter int MAX_POLLS   = 120
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [4:0] ltssm_state,
  output logic       link_up,
  output logic       timeout,
  output logic       done
);
  localparam int PW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam int NW = $clog2(MAX_POLLS + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_MS - 1);
  localparam logic [NW-1:0] POLL_MAX = NW'(MAX_POLLS);

  localparam logic [4:0] ST_ACTIVE  = 5'h11;
  localparam logic [4:0] ST_STANDBY = 5'h12;
  localparam logic [4:0] ST_L1_IDLE = 5'h14;

  logic          busy;
  logic [PW-1:0] pre;
  logic [NW-1:0] polls;

  wire is_up = (ltssm_state == ST_ACTIVE) || (ltssm_state == ST_STANDBY) ||
               (ltssm_state == ST_L1_IDLE);
  wire tick  = busy && (pre == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      pre     <= '0;
      polls   <= '0;
      link_up <= 1'b0;
      timeout <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      pre     <= '0;
      polls   <= NW'(1);
      timeout <= 1'b0;
      link_up <= is_up;
      done    <= is_up;
      busy    <= !is_up;
    end else if (busy) begin
      if (tick) begin
        pre <= '0;
        if (polls == POLL_MAX) begin
          timeout <= 1'b1;
          done    <= 1'b1;
          busy    <= 1'b0;
        end else if (is_up) begin
          link_up <= 1'b1;
          done    <= 1'b1;
          busy    <= 1'b0;
        end else begin
          polls <= polls + NW'(1);
        end
      end else begin
        pre <= pre + PW'(1);
      end
    end
  end
endmodule

// File: rtl/link_wait_monitor_chk.sv
module link_wait_monitor_chk #(
  parameter int CLKS_PER_MS = 100000,
  parameter int MAX_POLLS   = 120
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [4:0] ltssm_state,
  input logic       link_up,
  input logic       timeout,
  input logic       done
);
  localparam int LIMIT = CLKS_PER_MS * MAX_POLLS;
  localparam int CW    = $clog2(LIMIT + 2);

  logic [CW-1:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n)                      since <= '0;
    else if (start)                  since <= '0;
    else if (since != CW'(LIMIT + 1)) since <= since + CW'(1);
  end

  wire up_code = (ltssm_state == 5'h11) || (ltssm_state == 5'h12) ||
                 (ltssm_state == 5'h14);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_up && timeout));
  a_r9_done_match: assert property (@(posedge clk) disable iff (!rst_n)
    done == (link_up || timeout));
  a_r3_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    start && up_code |=> done && link_up);
  a_r2_l2_down: assert property (@(posedge clk) disable iff (!rst_n)
    start && (ltssm_state == 5'h15) |=> !done);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable({done, link_up, timeout}));
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start && !up_code |=> !done);
  a_r5_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) && !$past(start) |-> (since % CW'(CLKS_PER_MS)) == '0);
  a_r6_deadline: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> since == CW'(LIMIT));
endmodule

bind link_wait_monitor link_wait_monitor_chk #(
  .CLKS_PER_MS(CLKS_PER_MS),
  .MAX_POLLS(MAX_POLLS)
) u_chk (.*);

// File: tb/link_wait_monitor_tb.sv
module link_wait_monitor_tb;
  localparam int P = 20;
  localparam int M = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [4:0] st = 5'h00;
  wire        link_up, timeout, done;

  int n_chk = 0;
  int n_bad = 0;
  int tk;
  bit tgl, tfin;

  link_wait_monitor #(.CLKS_PER_MS(P), .MAX_POLLS(M)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ltssm_state(st),
    .link_up(link_up), .timeout(timeout), .done(done));

  function automatic bit up_code(logic [4:0] c);
    return (c == 5'h11) || (c == 5'h12) || (c == 5'h14);
  endfunction

  function automatic logic [4:0] rnd_down();
    logic [4:0] c;
    do c = 5'($urandom); while (up_code(c));
    return c;
  endfunction

  function automatic logic [4:0] rnd_up();
    case ($urandom % 3)
      0:       return 5'h11;
      1:       return 5'h12;
      default: return 5'h14;
    endcase
  endfunction

  function automatic logic [4:0] code_for(int m);
    if (tk >= 0 && m >= tk * P) return rnd_up();
    if (tgl && m == P / 2)      return rnd_up();
    if (tfin && m == M * P)     return rnd_up();
    return rnd_down();
  endfunction

  task automatic chk(string req, logic [2:0] exp);
    logic [2:0] act;
    act = {done, link_up, timeout};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {done,link_up,timeout} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic trial(int k, bit g, bit f, int pre, string req);
    int t;
    logic [2:0] exp;
    tk = k; tgl = g; tfin = f;
    if (pre > 0) begin
      st = rnd_down(); start = 1'b1;
      @(posedge clk); @(negedge clk); start = 1'b0;
      for (int i = 0; i < pre; i++) begin
        st = rnd_down();
        @(posedge clk); @(negedge clk);
      end
      chk("R8 before restart", 3'b000);
    end
    t   = (k >= 0) ? k * P : M * P;
    exp = (k >= 0) ? 3'b110 : 3'b101;
    st = code_for(0); start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    for (int n = 0; n < t; n++) begin
      if (n == t - 1) chk({req, " one cycle early"}, 3'b000);
      if (g && n == P / 2 + 1 && n < t) chk("R4 glitch ignored", 3'b000);
      st = code_for(n + 1);
      @(posedge clk); @(negedge clk);
    end
    chk({req, " result R9"}, exp);
    for (int i = 0; i < 6; i++) begin
      st = (i % 2 == 0) ? rnd_down() : rnd_up();
      @(posedge clk); @(negedge clk);
    end
    chk("R7 result held", exp);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 in reset", 3'b000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset", 3'b000);

    for (int c = 0; c < 32; c++) begin
      st = 5'(c); start = 1'b1;
      @(posedge clk); @(negedge clk); start = 1'b0;
      chk($sformatf("R2 R3 code %0h", c), up_code(5'(c)) ? 3'b110 : 3'b000);
    end

    trial(0, 0, 0, 0, "R3");
    trial(3, 1, 0, 0, "R4 R5");
    trial(1, 0, 0, 0, "R5 first boundary");
    trial(M - 1, 1, 0, 0, "R5 last boundary");
    trial(-1, 0, 0, 0, "R6");
    trial(-1, 1, 1, 0, "R6 final boundary up");
    trial(2, 0, 0, 3 * P + 5, "R8");

    for (int r = 0; r < 20; r++) begin
      int k;
      k = int'($urandom % (M + 1)) - 1;
      trial(k, 1'($urandom), 1'($urandom), ($urandom % 2) ? int'($urandom % (2 * P)) + 1 : 0,
            (k < 0) ? "R6 random" : "R5 random");
    end

    summary();
    $finish;
  end
endmodule